// File: doc/BRIEF.md
# Line Access Switch State Controller

This controller sets the on/off enables of a telephone line access switch array: a pair of break switches, a set of test switches, a ringing-return switch and a ringing switch. Two mode-select pins choose one of four line states. A hold input freezes the chosen mode. An active-low shutdown pin and a thermal-fault flag can force every switch open. The analog parts of the array are outside this block. They appear here only as digital pins: the shutdown pin's pull-up and buffer, the temperature sensor, and the current zero-crossing detector.

The ringing switch is a thyristor-style element and cannot break a live current. Once it is closed, any command to open it waits for the next zero-crossing strobe. While it waits, no other switch may close. This gives break-before-make behaviour on a ringing-to-talk change with no sequencing by the host. The shutdown pin is decoded after the hold stage. It therefore overrides a held mode, and the held mode comes back when shutdown is released.

All inputs pass through two-flop synchronizers and the switch enables are registered, so a pin change reaches the switches on the third rising clock edge. There is no data stream; every pin is a plain level or strobe.

Top module: `lsw_ctrl`

## Requirements
- R1: During reset and after reset, all four switch enables are 0, `drain_o` is 0 and `state_o` is 0 (all-off).
- R2: With `ring_sel_i`=0 and `test_sel_i`=0 (talk), only `brk_en_o` is 1 and `state_o` is 1.
- R3: With `ring_sel_i`=1 and `test_sel_i`=0 (ringing), only `ring_en_o` and `rret_en_o` are 1 and `state_o` is 2.
- R4: With `ring_sel_i`=0 and `test_sel_i`=1 (test), only `tst_en_o` is 1 and `state_o` is 3. With both selects at 1, all enables are 0 and `state_o` is 0.
- R5: A change on any input appears at the outputs on the third rising clock edge after it, and not before.
- R6: While `hold_i` is 0, the mode selects act directly. When `hold_i` goes from 0 to 1, the mode in force is captured. While `hold_i` stays 1, changes on the mode selects do not alter any output.
- R7: While `shdn_n_i` is 0, the break, test and ringing-return enables are 0 whatever `hold_i` or the mode selects are. When `shdn_n_i` returns to 1, the held mode (if any) is applied again.
- R8: `ring_en_o` goes from 1 to 0 only on the third rising edge after a `zc_i` pulse of at least one cycle. Every other enable opens on the normal latency, without waiting.
- R9: While the ringing switch is closed but no longer commanded, `drain_o` is 1, `state_o` is 4, and the break, test and ringing-return enables are all 0.
- R10: On a ringing-to-talk change, `brk_en_o` stays 0 until `ring_en_o` has opened, and both are never 1 together.
- R11: Thermal shutdown is active only when `shdn_n_i`=1 and `shdn_drv_i`=0 (pin floating). In that case `therm_i`=1 forces all-off as in R7. With `shdn_drv_i`=1 (pin driven high), `therm_i` has no effect.
- R12: A `zc_i` pulse while the ringing switch is either commanded on or already open changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sel_i | input | 1 | Mode select, ringing bit |
| test_sel_i | input | 1 | Mode select, test bit |
| hold_i | input | 1 | 1 holds the captured mode, 0 is transparent |
| shdn_n_i | input | 1 | Active-low shutdown, forces all-off |
| shdn_drv_i | input | 1 | 1 when the shutdown pin is driven rather than floating |
| therm_i | input | 1 | Thermal-fault flag |
| zc_i | input | 1 | Line-current zero-crossing strobe |
| brk_en_o | output | 1 | Break switch enable |
| tst_en_o | output | 1 | Test switch enable |
| rret_en_o | output | 1 | Ringing-return switch enable |
| ring_en_o | output | 1 | Ringing switch enable |
| drain_o | output | 1 | Ringing switch waiting for a zero crossing |
| state_o | output | 3 | 0 off, 1 talk, 2 ringing, 3 test, 4 ringing draining |

## Verification
The assertions assume that every pin stays quasi-static for at least one clock. They also assume that `hold_i` and the mode selects are never changed in the same cycle, so the mode captured at the hold edge is the one the mode selects held just before it. The stimulus drives every pin on the falling clock edge and holds each combination for several cycles. It raises or lowers `hold_i` only while the mode selects are steady, and gives `zc_i` as clean pulses of one or more full cycles.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_TALK  = 3'd1,
    ST_RING  = 3'd2,
    ST_TEST  = 3'd3,
    ST_DRAIN = 3'd4
  } lsw_state_e;

  typedef struct packed {
    logic brk;
    logic tst;
    logic rret;
    logic ring;
  } lsw_sw_t;

  localparam lsw_sw_t SW_NONE = '{brk: 1'b0, tst: 1'b0, rret: 1'b0, ring: 1'b0};

  // Mode select pair {ring_sel, test_sel} to commanded switch set.
  function automatic lsw_sw_t lsw_decode(input logic ring_sel, input logic test_sel);
    lsw_sw_t s;
    s = SW_NONE;
    unique case ({ring_sel, test_sel})
      2'b00: s.brk = 1'b1;
      2'b10: begin
        s.ring = 1'b1;
        s.rret = 1'b1;
      end
      2'b01: s.tst = 1'b1;
      default: s = SW_NONE;
    endcase
    return s;
  endfunction

  function automatic lsw_state_e lsw_classify(input lsw_sw_t s, input logic drain);
    lsw_state_e st;
    if (drain)       st = ST_DRAIN;
    else if (s.brk)  st = ST_TALK;
    else if (s.ring) st = ST_RING;
    else if (s.tst)  st = ST_TEST;
    else             st = ST_OFF;
    return st;
  endfunction

endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[LAST];

endmodule

// File: rtl/lsw_mode_latch.sv
module lsw_mode_latch
  import lsw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold,
  input  logic    ring_sel,
  input  logic    test_sel,
  output lsw_sw_t cmd
);

  logic [1:0] mode_q;
  logic [1:0] mode_eff;

  // Transparent while hold is low; the register follows so the last
  // transparent value is what remains once hold rises.
  assign mode_eff = hold ? mode_q : {ring_sel, test_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'b11;
    else        mode_q <= mode_eff;
  end

  assign cmd = lsw_decode(mode_eff[1], mode_eff[0]);

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(mode_eff));

endmodule

// File: rtl/lsw_switch_seq.sv
module lsw_switch_seq
  import lsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lsw_sw_t    cmd,
  input  logic       force_off,
  input  logic       zc,
  output lsw_sw_t    sw,
  output logic       drain,
  output lsw_state_e state
);

  lsw_sw_t    target;
  lsw_sw_t    sw_nx;
  logic       drain_nx;
  lsw_sw_t    sw_q;
  logic       drain_q;
  lsw_state_e state_q;

  always_comb begin
    target        = force_off ? SW_NONE : cmd;
    // Ringing switch: closes at once, opens only on a zero crossing.
    sw_nx.ring    = target.ring | (sw_q.ring & ~zc);
    drain_nx      = sw_nx.ring & ~target.ring;
    // Everything else opens at once and may not close while draining.
    sw_nx.brk     = target.brk  & ~drain_nx;
    sw_nx.tst     = target.tst  & ~drain_nx;
    sw_nx.rret    = target.rret & ~drain_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q    <= SW_NONE;
      drain_q <= 1'b0;
      state_q <= ST_OFF;
    end else begin
      sw_q    <= sw_nx;
      drain_q <= drain_nx;
      state_q <= lsw_classify(sw_nx, drain_nx);
    end
  end

  assign sw    = sw_q;
  assign drain = drain_q;
  assign state = state_q;

  // R8
  ring_zc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_q.ring) |-> $past(zc));

  // R9
  drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> !(sw_q.brk || sw_q.tst || sw_q.rret) && sw_q.ring);

  // R7
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_off) |-> !(sw_q.brk || sw_q.tst || sw_q.rret));

  // R10
  no_brk_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q.brk |-> !sw_q.ring);

endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ring_sel_i,
  input  logic       test_sel_i,
  input  logic       hold_i,
  input  logic       shdn_n_i,
  input  logic       shdn_drv_i,
  input  logic       therm_i,
  input  logic       zc_i,
  output logic       brk_en_o,
  output logic       tst_en_o,
  output logic       rret_en_o,
  output logic       ring_en_o,
  output logic       drain_o,
  output logic [2:0] state_o
);

  localparam int unsigned NUM_IN = 7;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] syn_in;
  logic              ring_s, test_s, hold_s, shdn_n_s, shdn_drv_s, therm_s, zc_s;
  logic              force_off;
  lsw_sw_t           cmd;
  lsw_sw_t           sw;
  lsw_state_e        state;

  assign raw_in = {ring_sel_i, test_sel_i, hold_i, shdn_n_i, shdn_drv_i, therm_i, zc_i};

  lsw_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  assign {ring_s, test_s, hold_s, shdn_n_s, shdn_drv_s, therm_s, zc_s} = syn_in;

  lsw_mode_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold_s),
    .ring_sel (ring_s),
    .test_sel (test_s),
    .cmd      (cmd)
  );

  // Shutdown bypasses the hold stage; thermal trip only while the pin floats.
  assign force_off = ~shdn_n_s | (therm_s & ~shdn_drv_s);

  lsw_switch_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .force_off (force_off),
    .zc        (zc_s),
    .sw        (sw),
    .drain     (drain_o),
    .state     (state)
  );

  assign brk_en_o  = sw.brk;
  assign tst_en_o  = sw.tst;
  assign rret_en_o = sw.rret;
  assign ring_en_o = sw.ring;
  assign state_o   = state;

endmodule

// File: tb/lsw_ctrl_test.sv
`timescale 1ns/1ps
module lsw_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ring_sel, test_sel, hold, shdn_n, shdn_drv, therm, zc;
  logic brk, tst, rret, ring, drain;
  logic [2:0] state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsw_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .ring_sel_i(ring_sel), .test_sel_i(test_sel), .hold_i(hold),
    .shdn_n_i(shdn_n), .shdn_drv_i(shdn_drv), .therm_i(therm), .zc_i(zc),
    .brk_en_o(brk), .tst_en_o(tst), .rret_en_o(rret), .ring_en_o(ring),
    .drain_o(drain), .state_o(state)
  );

  // Inputs {ring,test,hold,shdn_n,drv,therm,zc}, outputs {brk,tst,rret,ring,drain,state[2:0]}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {7'b0001000, 8'b1000_0001},  // R2 talk
    {7'b0101000, 8'b0100_0011},  // R4 test
    {7'b1101000, 8'b0000_0000},  // R4 both set -> off
    {7'b1001000, 8'b0011_0010},  // R3 ringing
    {7'b1001110, 8'b0011_0010},  // R11 driven high: fault ignored
    {7'b1001010, 8'b0001_1100},  // R11 floating: fault trips, R9 draining
    {7'b1001011, 8'b0000_0000},  // R8 zero crossing releases ring
    {7'b1001000, 8'b0011_0010},  // R3 ringing again
    {7'b0001000, 8'b0001_1100},  // R10 ring->talk, break held off
    {7'b0001001, 8'b1000_0001},  // R10 break closes after ring opens
    {7'b0101001, 8'b0100_0011},  // R12 zc with ring open: no effect
    {7'b0111000, 8'b0100_0011},  // R6 capture test mode
    {7'b1011000, 8'b0100_0011},  // R6 held: mode change ignored
    {7'b0010000, 8'b0000_0000},  // R7 shutdown over held mode
    {7'b0011000, 8'b0100_0011},  // R7 held mode returns
    {7'b0001000, 8'b1000_0001}   // R6 transparent again
  };

  function automatic logic [7:0] outs();
    return {brk, tst, rret, ring, drain, state};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {ring_sel, test_sel, hold, shdn_n, shdn_drv, therm, zc} = v;
  endtask

  initial begin
    drive(7'b0001000);
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 8'h00);
    @(negedge clk) rst_n = 1'b1;
    check("R1 after reset", outs(), 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(VEC[i][14:8]);
      repeat (4) @(negedge clk);
      check($sformatf("vector %0d", i), outs(), VEC[i][7:0]);
    end

    // R5: talk -> ringing latency is exactly three edges
    @(negedge clk) drive(7'b1001000);
    @(negedge clk);
    check("R5 edge1", outs(), 8'b1000_0001);
    @(negedge clk);
    check("R5 edge2", outs(), 8'b1000_0001);
    @(negedge clk);
    check("R5 edge3", outs(), 8'b0011_0010);

    // R8: go off, ring drains, one-cycle zc opens it on third edge
    @(negedge clk) drive(7'b1101000);
    repeat (4) @(negedge clk);
    check("R8 draining", outs(), 8'b0001_1100);
    drive(7'b1101001);
    @(negedge clk) drive(7'b1101000);
    @(negedge clk);
    check("R8 zc edge2", outs(), 8'b0001_1100);
    @(negedge clk);
    check("R8 zc edge3", outs(), 8'b0000_0000);

    // R12: zc pulse while all open
    drive(7'b1101001);
    @(negedge clk) drive(7'b1101000);
    repeat (4) @(negedge clk);
    check("R12 idle zc", outs(), 8'b0000_0000);

    // R1: reset mid-run from talk
    @(negedge clk) drive(7'b0001000);
    repeat (4) @(negedge clk);
    check("R2 talk before reset", outs(), 8'b1000_0001);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", outs(), 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 talk after reset", outs(), 8'b1000_0001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule